// File: doc/BRIEF.md
# Interrupt Mask and Sticky Status Unit

This block collects the event and level indications of a serial port's datapath into one 32-bit status word and turns them into a single interrupt request. Error and protocol events arrive as one-cycle pulses. Each pulse sets a flag that stays set until software clears it. Level indications, such as receiver-ready or transmitter-empty, pass straight through to the status word. The unit also synchronizes the clear-to-send input, shows its current level, and flags every change of that level.

Software controls which status bits can raise the interrupt through two write-only ports. On the enable port, each 1 turns a mask bit on. On the disable port, each 1 turns a mask bit off. The resulting mask can be read back.

Sticky flags are cleared in three different ways. A group-clear command clears all of the error flags together. The non-acknowledge flag has a clear command of its own. The clear-to-send change flag clears when software reads the status word. The interrupt output is the registered OR of the status word ANDed with the mask.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, mask_o is 0x00000000 and irq_o is 0. Every sticky flag is clear. status_o shows only the live inputs and the clear-to-send level in bit 23 (0x00800000 while cts_i is held high).
- R2: With en_we_i high, each 1 in en_data_i sets the matching implemented mask bit. Bits written as 0 keep their value.
- R3: With dis_we_i high, each 1 in dis_data_i clears the matching mask bit. Bits written as 0 keep their value.
- R4: If both write ports carry a 1 for the same bit in one cycle, that mask bit ends up 0.
- R5: An evt_i pulse on a group bit sets that status bit, and the bit stays set. The group bits are 2, 5, 6, 7, 10, 14, 15 and 24 to 29.
- R6: A grp_clr_i pulse clears every group bit. It leaves the non-acknowledge flag (bit 13) unchanged.
- R7: The non-acknowledge flag (bit 13) is set by evt_i[13] and is cleared only by nack_clr_i.
- R8: If an event pulse and the clear that covers its flag arrive in the same cycle, the flag is set after that cycle.
- R9: Status bit 23 shows the synchronized cts_i level. Any change of that level sets bit 19. A status read (stat_rd_i) clears bit 19 unless a new change is detected in the same cycle.
- R10: Status bits 0, 1, 3, 4, 8, 9, 11 and 12 follow live_i without storage.
- R11: irq_o equals the OR of (status_o AND mask_o) as it was one clock earlier.
- R12: Bits outside the implemented set read as 0 in both status_o and mask_o. The implemented set for mask_o is 0x3F08FFFF. Bit 23 is also readable in status_o but cannot be masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_we_i | input | 1 | Write strobe of the mask enable port |
| en_data_i | input | 32 | Write-1-to-set data for the mask |
| dis_we_i | input | 1 | Write strobe of the mask disable port |
| dis_data_i | input | 32 | Write-1-to-clear data for the mask |
| mask_o | output | 32 | Current interrupt mask |
| evt_i | input | 32 | Event pulses that set sticky flags |
| live_i | input | 32 | Level indications from the datapath |
| grp_clr_i | input | 1 | Clears all group sticky flags |
| nack_clr_i | input | 1 | Clears the non-acknowledge flag |
| cts_i | input | 1 | Asynchronous clear-to-send input |
| stat_rd_i | input | 1 | Status read strobe; clears the change flag |
| status_o | output | 32 | Status word |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a status read that falls in exactly the cycle in which a new clear-to-send change is detected. That edge is only seen after the synchronizer stages, so the read has to be placed relative to the cts_i toggle rather than relative to the status bit. The stimulus toggles cts_i on a falling clock edge. It then counts two rising edges through the synchronizer and raises stat_rd_i for the cycle in which the detector compares the new level against the old one. The same collision is driven for the group and non-acknowledge clears, by pulsing an event together with its clear.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned STAT_W = 32;
  typedef logic [STAT_W-1:0] stat_vec_t;

  localparam int unsigned BIT_NACK  = 13;
  localparam int unsigned BIT_CTSIC = 19;
  localparam int unsigned BIT_CTS   = 23;

  // sticky flags cleared by the group command
  localparam stat_vec_t GRP_BITS =
      (stat_vec_t'(1) << 2)  | (stat_vec_t'(1) << 5)  | (stat_vec_t'(1) << 6)  |
      (stat_vec_t'(1) << 7)  | (stat_vec_t'(1) << 10) | (stat_vec_t'(1) << 14) |
      (stat_vec_t'(1) << 15) | (stat_vec_t'(63) << 24);

  // level indications passed through
  localparam stat_vec_t LIVE_BITS =
      (stat_vec_t'(3) << 0) | (stat_vec_t'(3) << 3) | (stat_vec_t'(3) << 8) |
      (stat_vec_t'(3) << 11);

  localparam stat_vec_t MASKABLE = GRP_BITS | LIVE_BITS |
                                   (stat_vec_t'(1) << BIT_NACK) |
                                   (stat_vec_t'(1) << BIT_CTSIC);
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W   = 32,
  parameter logic [W-1:0] IMP = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] set_v, clr_v, mask_q;

  assign set_v = set_we_i ? (set_i & IMP) : '0;
  assign clr_v = clr_we_i ? clr_i : '0;

  // clear applied last: disable wins on collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q | set_v) & ~clr_v;
  end

  assign mask_o = mask_q;

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i && !clr_we_i |=> (mask_q & $past(set_i & IMP)) == $past(set_i & IMP));

  p_dis_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> (mask_q & $past(clr_i)) == '0);

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_we_i && !clr_we_i |=> $stable(mask_q));
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int unsigned  W        = 32,
  parameter logic [W-1:0] GRP      = '0,
  parameter int unsigned  SOLO_BIT = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         grp_clr_i,
  input  logic         solo_clr_i,
  output logic [W-1:0] flag_o
);
  localparam logic [W-1:0] USED = GRP | (W'(1) << SOLO_BIT);

  logic unused_evt;
  assign unused_evt = ^(evt_i & ~USED);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (GRP[i]) begin : g_grp
      logic f_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= 1'b0;
        else         f_q <= evt_i[i] | (f_q & ~grp_clr_i);
      end
      assign flag_o[i] = f_q;
    end else if (i == SOLO_BIT) begin : g_solo
      logic f_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= 1'b0;
        else         f_q <= evt_i[i] | (f_q & ~solo_clr_i);
      end
      assign flag_o[i] = f_q;
    end else begin : g_none
      assign flag_o[i] = 1'b0;
    end
  end

  p_evt_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i & GRP) != '0 |=> (flag_o & $past(evt_i & GRP)) == $past(evt_i & GRP));

  p_grp_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_clr_i && (evt_i & GRP) == '0 |=> (flag_o & GRP) == '0);

  p_solo_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !solo_clr_i && flag_o[SOLO_BIT] |=> flag_o[SOLO_BIT]);

  p_set_beats_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo_clr_i && evt_i[SOLO_BIT] |=> flag_o[SOLO_BIT]);
endmodule

// File: rtl/irq_cts_monitor.sv
module irq_cts_monitor #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_i,
  input  logic rd_i,
  output logic level_o,
  output logic change_o
);
  logic [STAGES-1:0] sync_q;
  logic prev_q, chg_q, edge_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{RST_LVL}};
      prev_q <= RST_LVL;
      chg_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], cts_i};
      prev_q <= sync_q[STAGES-1];
      chg_q  <= edge_w | (chg_q & ~rd_i);
    end
  end

  assign edge_w   = sync_q[STAGES-1] ^ prev_q;
  assign level_o  = sync_q[STAGES-1];
  assign change_o = chg_q;

  p_edge_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_w |=> change_o);

  p_read_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !edge_w |=> !change_o);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int unsigned CTS_STAGES = 2,
  parameter logic        CTS_IDLE   = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_we_i,
  input  logic [31:0] en_data_i,
  input  logic        dis_we_i,
  input  logic [31:0] dis_data_i,
  output logic [31:0] mask_o,
  input  logic [31:0] evt_i,
  input  logic [31:0] live_i,
  input  logic        grp_clr_i,
  input  logic        nack_clr_i,
  input  logic        cts_i,
  input  logic        stat_rd_i,
  output logic [31:0] status_o,
  output logic        irq_o
);
  stat_vec_t mask_w, sticky_w, status_w;
  logic cts_lvl_w, cts_chg_w, irq_q;
  logic unused_live;

  assign unused_live = ^(live_i & ~LIVE_BITS);

  irq_mask_reg #(.W(STAT_W), .IMP(MASKABLE)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (en_we_i),
    .set_i    (en_data_i),
    .clr_we_i (dis_we_i),
    .clr_i    (dis_data_i),
    .mask_o   (mask_w)
  );

  irq_sticky_bank #(.W(STAT_W), .GRP(GRP_BITS), .SOLO_BIT(BIT_NACK)) u_sticky (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .grp_clr_i  (grp_clr_i),
    .solo_clr_i (nack_clr_i),
    .flag_o     (sticky_w)
  );

  irq_cts_monitor #(.STAGES(CTS_STAGES), .RST_LVL(CTS_IDLE)) u_cts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cts_i    (cts_i),
    .rd_i     (stat_rd_i),
    .level_o  (cts_lvl_w),
    .change_o (cts_chg_w)
  );

  always_comb begin
    status_w            = (live_i & LIVE_BITS) | sticky_w;
    status_w[BIT_CTSIC] = cts_chg_w;
    status_w[BIT_CTS]   = cts_lvl_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_w & mask_w);
  end

  assign mask_o   = mask_w;
  assign status_o = status_w;
  assign irq_o    = irq_q;

  p_irq_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & mask_o) == '0 |=> !irq_o);

  p_irq_high_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & mask_o) != '0 |=> irq_o);

  p_mask_impl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> (mask_o & ~$past(mask_o) & ~MASKABLE) == '0);
endmodule

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, en_we, dis_we, grp_clr, nack_clr, cts, stat_rd, irq;
  logic [31:0] en_data, dis_data, evt, live, mask, status;
  int n_chk = 0, n_fail = 0;

  irq_status_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .en_we_i(en_we), .en_data_i(en_data),
    .dis_we_i(dis_we), .dis_data_i(dis_data), .mask_o(mask), .evt_i(evt),
    .live_i(live), .grp_clr_i(grp_clr), .nack_clr_i(nack_clr), .cts_i(cts),
    .stat_rd_i(stat_rd), .status_o(status), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] e, logic [31:0] d, logic we_e, logic we_d);
    en_we = we_e; en_data = e; dis_we = we_d; dis_data = d;
    cyc();
    en_we = 0; en_data = 0; dis_we = 0; dis_data = 0;
  endtask

  task automatic pulse(logic [31:0] e, logic g, logic n);
    evt = e; grp_clr = g; nack_clr = n;
    cyc();
    evt = 0; grp_clr = 0; nack_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 mask after reset", mask, 32'h0);
    chk("R1 status after reset", status, 32'h0080_0000);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask();
    wr(32'h0000_00A5, 0, 1, 0); chk("R2 enable set", mask, 32'h0000_00A5);
    wr(32'h0000_0100, 0, 1, 0); chk("R2 zeros keep", mask, 32'h0000_01A5);
    wr(0, 32'h0000_0005, 0, 1); chk("R3 disable clear", mask, 32'h0000_01A0);
    wr(0, 32'h0, 0, 1);         chk("R3 zero disable", mask, 32'h0000_01A0);
    wr(32'hFFFF_FFFF, 0, 1, 0); chk("R12 implemented mask", mask, 32'h3F08_FFFF);
    wr(0, 32'hFFFF_FFFF, 0, 1); chk("R3 clear all", mask, 32'h0);
  endtask

  task automatic t_both();
    wr(32'h0000_0031, 32'h0000_0030, 1, 1); chk("R4 disable wins", mask, 32'h0000_0001);
    wr(0, 32'h0000_0001, 0, 1);
  endtask

  task automatic t_sticky();
    pulse(32'h0000_00E4, 0, 0); chk("R5 set", status & 32'hFF7F_FFFF, 32'h0000_00E4);
    cyc(3);                     chk("R5 hold", status & 32'hFF7F_FFFF, 32'h0000_00E4);
    pulse(32'h3F00_C400, 0, 0); chk("R5 upper", status & 32'hFF7F_FFFF, 32'h3F00_C4E4);
    pulse(32'hC076_0000, 0, 0); chk("R12 unimpl evt", status & 32'hFF7F_FFFF, 32'h3F00_C4E4);
  endtask

  task automatic t_clears();
    pulse(32'h0000_2000, 0, 0); chk("R7 nack set", status & 32'hFF7F_FFFF, 32'h3F00_E4E4);
    pulse(0, 1, 0);             chk("R6 group clear", status & 32'hFF7F_FFFF, 32'h0000_2000);
    pulse(0, 1, 0);             chk("R7 group leaves nack", status & 32'hFF7F_FFFF, 32'h0000_2000);
    pulse(0, 0, 1);             chk("R7 nack clear", status & 32'hFF7F_FFFF, 32'h0);
  endtask

  task automatic t_collide();
    pulse(32'h0000_0080, 1, 0); chk("R8 event vs group", status & 32'hFF7F_FFFF, 32'h0000_0080);
    pulse(32'h0000_2000, 0, 1); chk("R8 event vs nack", status & 32'hFF7F_FFFF, 32'h0000_2080);
    pulse(0, 1, 1);             chk("R8 cleanup", status & 32'hFF7F_FFFF, 32'h0);
  endtask

  task automatic t_live();
    live = 32'hFFFF_FFFF; cyc(); chk("R10 live high", status & 32'hFF7F_FFFF, 32'h0000_1B1B);
    live = 32'h0000_0A12; cyc(); chk("R10 live pattern", status & 32'hFF7F_FFFF, 32'h0000_0A12);
    live = 0;             cyc(); chk("R10 live low", status & 32'hFF7F_FFFF, 32'h0);
  endtask

  task automatic t_cts();
    cts = 0; cyc(2); chk("R9 level after sync", status & 32'h0088_0000, 32'h0);
    cyc();           chk("R9 change set", status & 32'h0088_0000, 32'h0008_0000);
    cyc(2);          chk("R9 change held", status & 32'h0088_0000, 32'h0008_0000);
    stat_rd = 1; cyc(); stat_rd = 0;
    chk("R9 read clears", status & 32'h0088_0000, 32'h0);
    cts = 1; cyc(2); stat_rd = 1; cyc(); stat_rd = 0;
    chk("R9 edge beats read", status & 32'h0088_0000, 32'h0088_0000);
    stat_rd = 1; cyc(); stat_rd = 0;
    chk("R9 second read", status & 32'h0088_0000, 32'h0080_0000);
  endtask

  task automatic t_irq();
    wr(32'h0000_0080, 0, 1, 0);
    pulse(32'h0000_0080, 0, 0); chk("R11 irq lags", {31'b0, irq}, 32'h0);
    cyc();                      chk("R11 irq raised", {31'b0, irq}, 32'h1);
    pulse(0, 1, 0);             chk("R11 irq still registered", {31'b0, irq}, 32'h1);
    cyc();                      chk("R11 irq dropped", {31'b0, irq}, 32'h0);
    pulse(32'h0000_0040, 0, 0); cyc(2);
    chk("R11 masked flag no irq", {31'b0, irq}, 32'h0);
    wr(32'h0000_0001, 0, 1, 0);
    live = 32'h1; cyc();        chk("R11 live irq", {31'b0, irq}, 32'h1);
    live = 0; pulse(0, 1, 0); wr(0, 32'hFFFF_FFFF, 0, 1);
    cyc();                      chk("R11 irq idle", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; en_we = 0; dis_we = 0; en_data = 0; dis_data = 0; evt = 0;
    live = 0; grp_clr = 0; nack_clr = 0; cts = 1; stat_rd = 0;
    cyc(3); rst_n = 1; cyc();
    t_reset();
    t_mask();
    t_both();
    t_sticky();
    t_clears();
    t_collide();
    t_live();
    t_cts();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule